// File: doc/BRIEF.md
# Processor control instruction unit

This unit carries out the processor-control instructions of a 16-bit CPU core. A decode stage hands it a 3-bit opcode together with a valid strobe. The unit then does one of the following:

- clears the string direction flag;
- spends a cycle doing nothing;
- parks the core until reset;
- suspends issue until an external active-low readiness pin goes low;
- asserts a bus-lock output for the one instruction that follows a lock prefix.

Escape opcodes belong to an attached coprocessor. This unit treats them as idle cycles.

The fetch stage watches `stall`. While `stall` is high, the unit accepts no instruction. The external pin is brought into the clock domain through a two-flop synchronizer before the wait logic looks at it. A separate request input lets the rest of the flag logic set the direction flag. After a synchronous reset, `restart_addr` presents the 20-bit address where fetch resumes.

Top module: `proc_ctl_unit`

## Requirements
- R1: In the cycle after a synchronous reset, `dir_flag`, `bus_lock`, `halted` and `stall` are all 0. The test synchronizer is preset to "not ready" (high).
- R2: When opcode 1 (clear direction) is accepted, `dir_flag` is 0 in the next cycle. Otherwise, `df_set_req` high makes `dir_flag` 1 in the next cycle. If neither applies, `dir_flag` holds its value.
- R3: Opcode 0 (no-op), opcode 4 (escape) and the unused codes 6 and 7 leave `dir_flag`, `halted` and `stall` unchanged. They count as completed instructions for R7.
- R4: When opcode 2 (halt) is accepted, `halted` and `stall` go to 1 in the next cycle. Both stay at 1 until a reset, whatever the instruction inputs do.
- R5: Opcode 3 (wait) accepted while the synchronized test level is high raises `stall` in the next cycle. `stall` stays high while the synchronized level is high. It falls in the cycle after the synchronized level is seen low. A level on `test_n` reaches the synchronized value after two clock edges.
- R6: Opcode 3 accepted while the synchronized test level is already low completes at once, and `stall` never rises.
- R7: `bus_lock` rises in the cycle after opcode 5 (lock) is accepted. It falls in the cycle after the next non-lock instruction completes, so a lock followed by a wait keeps `bus_lock` high through the whole wait. Back-to-back lock opcodes keep it high.
- R8: While `stall` is high, `instr_valid` is ignored: no opcode takes effect.
- R9: From the cycle after reset, `restart_addr` reads the parameter `RESTART` (default 20'hFFFF0). It holds that value until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Opcode strobe from decode |
| instr_op | input | 3 | Encoded control opcode |
| test_n | input | 1 | Asynchronous external readiness pin, active low |
| df_set_req | input | 1 | Request from the flag logic to set the direction flag |
| dir_flag | output | 1 | Direction flag |
| bus_lock | output | 1 | Bus lock, high for the locked instruction |
| halted | output | 1 | Core halted until reset |
| stall | output | 1 | Fetch must hold; no instruction is accepted |
| restart_addr | output | 20 | Fetch address after reset |

## Verification
A corrupted internal state reaches the ports within one clock:
- A wrong control state shows up directly on `stall` and `halted`.
- A lost or stuck lock shows up on `bus_lock`.

One case is slower. A synchronizer fault, or a wait state that reads the raw pin, shows up only as `stall` being released one or two cycles early or late. For that reason, the reference model compares every output on every cycle, including the cycles in which the pin changes while a wait is pending.

// File: rtl/proc_ctl_unit.sv
module proc_ctl_unit #(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] RESTART = 20'hFFFF0,
  parameter int OP_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [OP_W-1:0]   instr_op,
  input  logic              test_n,
  input  logic              df_set_req,
  output logic              dir_flag,
  output logic              bus_lock,
  output logic              halted,
  output logic              stall,
  output logic [ADDR_W-1:0] restart_addr
);

  localparam logic [OP_W-1:0] OP_CLD  = OP_W'(1);
  localparam logic [OP_W-1:0] OP_HALT = OP_W'(2);
  localparam logic [OP_W-1:0] OP_WAIT = OP_W'(3);
  localparam logic [OP_W-1:0] OP_LOCK = OP_W'(5);

  typedef enum logic [1:0] {S_RUN, S_WAIT, S_HALT} ctl_state_t;

  ctl_state_t state;
  logic [SYNC_STAGES-1:0] sync;
  logic test_hi, accept, wait_clears, instr_done;

  assign test_hi = sync[SYNC_STAGES-1];
  assign accept  = instr_valid && (state == S_RUN);
  assign halted  = (state == S_HALT);
  assign stall   = (state != S_RUN);

  assign wait_clears = (state == S_WAIT) && !test_hi;
  assign instr_done  = (accept && instr_op != OP_LOCK &&
                        !(instr_op == OP_WAIT && test_hi)) || wait_clears;

  always_ff @(posedge clk) begin
    if (rst) sync <= '1;
    else     sync <= {sync[SYNC_STAGES-2:0], test_n};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_RUN;
    end else begin
      case (state)
        S_RUN: begin
          if (accept && instr_op == OP_HALT) state <= S_HALT;
          else if (accept && instr_op == OP_WAIT && test_hi) state <= S_WAIT;
        end
        S_WAIT:  if (!test_hi) state <= S_RUN;
        default: state <= S_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dir_flag <= 1'b0;
    else if (accept && instr_op == OP_CLD) dir_flag <= 1'b0;
    else if (df_set_req) dir_flag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_lock <= 1'b0;
    else if (accept && instr_op == OP_LOCK) bus_lock <= 1'b1;
    else if (instr_done) bus_lock <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) restart_addr <= RESTART;
  end

  // R2
  clr_df_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !stall && instr_op == OP_CLD) |=> !dir_flag);

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && stall));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !halted && test_hi) |=> stall);

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !stall && instr_op == OP_LOCK) |=> bus_lock);

  // R8
  stall_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !df_set_req) |=> $stable(dir_flag));

endmodule

// File: tb/tb_proc_ctl_unit.sv
module tb_proc_ctl_unit;
  logic clk = 0, rst = 1, instr_valid = 0, test_n = 1, df_set_req = 0;
  logic [2:0] instr_op = 0;
  logic dir_flag, bus_lock, halted, stall;
  logic [19:0] restart_addr;

  int compared = 0, mismatched = 0;
  string phase = "R1 reset";

  // reference model state
  int m_df = 0, m_lock = 0, m_st = 0, m_t1 = 1, m_t2 = 1;
  int m_ra = 'hFFFF0;

  always #10 clk = ~clk;

  proc_ctl_unit dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_op(instr_op),
    .test_n(test_n), .df_set_req(df_set_req), .dir_flag(dir_flag),
    .bus_lock(bus_lock), .halted(halted), .stall(stall),
    .restart_addr(restart_addr));

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int op, acc, n_st, n_df, n_lock, done;
    op  = int'(instr_op);
    if (rst) begin
      m_df = 0; m_lock = 0; m_st = 0; m_t1 = 1; m_t2 = 1; m_ra = 'hFFFF0;
    end else begin
      acc = (instr_valid && m_st == 0) ? 1 : 0;
      n_st = m_st; n_df = m_df; n_lock = m_lock; done = 0;
      if (acc && op == 2) n_st = 2;
      if (acc && op == 3) begin
        if (m_t2 == 1) n_st = 1; else done = 1;
      end
      if (acc && op != 3 && op != 5) done = 1;
      if (m_st == 1 && m_t2 == 0) begin n_st = 0; done = 1; end
      if (acc && op == 1) n_df = 0;
      else if (df_set_req) n_df = 1;
      if (acc && op == 5) n_lock = 1;
      else if (done) n_lock = 0;
      m_st = n_st; m_df = n_df; m_lock = n_lock;
      m_t2 = m_t1; m_t1 = int'(test_n);
    end
    #5;
    chk("R2", int'(dir_flag), m_df);
    chk("R7", int'(bus_lock), m_lock);
    chk("R4", int'(halted), (m_st == 2) ? 1 : 0);
    chk("R5", int'(stall), (m_st != 0) ? 1 : 0);
    chk("R9", int'(restart_addr), m_ra);
  end

  task automatic issue(int op, int tn = -1);
    @(negedge clk);
    instr_valid = 1; instr_op = 3'(op);
    if (tn >= 0) test_n = tn[0];
    @(negedge clk);
    instr_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; test_n = 1;
    idle(2); rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle(3); rst = 0;
    @(negedge clk);
    // R1 explicit reset state
    chk("R1", int'({dir_flag, bus_lock, halted, stall}), 0);
    chk("R1", int'(restart_addr), 'hFFFF0);

    phase = "R2 set/clear";
    @(negedge clk); df_set_req = 1; @(negedge clk); df_set_req = 0;
    chk("R2", int'(dir_flag), 1);
    issue(1);
    chk("R2", int'(dir_flag), 0);
    @(negedge clk); df_set_req = 1; instr_valid = 1; instr_op = 1;
    @(negedge clk); df_set_req = 0; instr_valid = 0;

    phase = "R3 idle opcodes";
    @(negedge clk); df_set_req = 1; @(negedge clk); df_set_req = 0;
    issue(0); issue(4); issue(6); issue(7);
    chk("R3", int'({dir_flag, halted, stall}), 3'b100);

    phase = "R6 wait ready";
    test_n = 0; idle(3);
    issue(3);
    chk("R6", int'(stall), 0);

    phase = "R5 wait stall";
    test_n = 1; idle(3);
    issue(3);
    chk("R5", int'(stall), 1);
    issue(1); idle(4);
    chk("R8", int'(dir_flag), 1);
    test_n = 0; idle(4);
    chk("R5", int'(stall), 0);

    phase = "R7 lock then wait";
    test_n = 1; idle(3);
    issue(5); issue(3);
    idle(5);
    chk("R7", int'(bus_lock), 1);
    test_n = 0; idle(4);
    chk("R7", int'(bus_lock), 0);

    phase = "R7 lock chain";
    issue(5); issue(5); issue(5); issue(4); idle(2);
    issue(5); issue(0); idle(1);

    phase = "R3 mixed stream";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      instr_valid = $urandom_range(0, 1);
      instr_op = 3'($urandom_range(0, 7));
      if (instr_op == 2) instr_op = 0;
      test_n = $urandom_range(0, 3) != 0;
      df_set_req = ($urandom_range(0, 5) == 0);
    end
    @(negedge clk); instr_valid = 0; df_set_req = 0; test_n = 0; idle(5);

    phase = "R4 halt";
    issue(5); issue(2);
    chk("R4", int'({halted, stall}), 2'b11);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); instr_valid = 1; instr_op = 3'(i % 8); test_n = i[0];
    end
    @(negedge clk); instr_valid = 0;
    chk("R4", int'({halted, stall}), 2'b11);

    phase = "R1 reset from halt";
    do_reset();
    @(negedge clk);
    chk("R1", int'({dir_flag, bus_lock, halted, stall}), 0);
    chk("R9", int'(restart_addr), 'hFFFF0);
    idle(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule